// File: doc/BRIEF.md
# MDIO PHY Management Controller

This block is the management-port master of an Ethernet MAC. Software puts a complete PHY access into one 32-bit maintenance word. The word carries the operation, the PHY address, the register number and, for a write, the data. The controller then sends a clause-22 management frame on MDC/MDIO. For a read, it captures the 16 bits that the PHY returns into the low half of the same word.

A status bit reports whether the port is idle and can take a new command. A control bit gates the port as a whole. MDC is made by dividing the system clock with a parameterised divisor. The divisor defaults to 48, which keeps MDC legal for system clocks up to 120 MHz. The MDIO pin is split into output, output-enable and input, so the tristate buffer can sit at the pad.

Three registers are visible on a small word-addressed port:
- offset 0: control
- offset 1: status
- offset 2: maintenance word
- offset 3: reads zero

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: Every frame is 64 MDC periods, sent MSB first: 32 ones, start bits 01, a two-bit opcode, the PHY address from maintenance bits 27:23, the register number from bits 22:18, two turnaround bits, then 16 data bits.
- R2: A maintenance write starts a frame only if bits 30 and 17 are both 1 and exactly one of bit 29 (read, opcode 10) and bit 28 (write, opcode 01) is set. Any other value is ignored: the word keeps its old contents, MDC stays low and status stays idle.
- R3: A write frame drives turnaround 10 followed by maintenance bits 15:0, and mdio_oe stays high for all 64 periods. After the frame, the word reads back exactly as written.
- R4: A read frame releases MDIO (mdio_oe low) from the first turnaround period to the end of the frame. It samples mdio_i on each rising MDC edge of the 16 data periods. At the end it places the result in maintenance bits 15:0 and keeps the written bits 31:16.
- R5: Status bit 2 reads 1 when the port is idle. It reads 0 from the cycle after an accepted command until the frame ends. All other status bits read 0.
- R6: Control bit 4 is the port enable and reads back as written; it resets to 0. A maintenance write made while the enable is 0 is ignored.
- R7: Clearing the enable during a frame aborts the frame. By the second cycle after the control write, status reads idle, and MDC and mdio_oe are low. No further MDC edges follow.
- R8: A maintenance write made while a frame is in progress is ignored. The frame in flight and the stored word are unaffected.
- R9: During a frame, MDC has a period of CLK_DIV system clocks. It is low for CLK_DIV/2 clocks (integer division) and high for the rest. MDC is held low whenever the port is idle.
- R10: mdio_o and mdio_oe change only on the falling edge of MDC, and stay stable while MDC is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset (0 control, 1 status, 2 maintenance) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_i | input | 1 | MDIO pad input |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |

## Verification
The bench builds the controller with CLK_DIV set to 8. A whole frame then takes 512 system clocks, which leaves room for many write and read frames plus the abort, busy-write and invalid-command cases within the run. Because 8 is even, the high and low MDC phases should each last exactly 4 clocks, and the bench measures them on every edge. A bench PHY model decodes each frame at the rising MDC edges and answers reads with chosen patterns, including all ones and all zeros.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 32;
    localparam int BIDX_W     = $clog2(FRAME_BITS);
    localparam int TA_IDX     = PRE_BITS + 14;
    localparam int DATA_IDX   = PRE_BITS + 16;

    localparam int MW_MARK_HI = 30;
    localparam int MW_RD      = 29;
    localparam int MW_WR      = 28;
    localparam int MW_PHY_LSB = 23;
    localparam int MW_REG_LSB = 18;
    localparam int MW_MARK_LO = 17;

    localparam int CTRL_EN_BIT   = 4;
    localparam int STAT_IDLE_BIT = 2;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_MAINT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic        is_read;
        logic [4:0]  phy;
        logic [4:0]  regn;
        logic [15:0] wdata;
    } mdio_cmd_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0]  op;
        logic [1:0]  ta;
        logic [15:0] dat;
        op  = c.is_read ? 2'b10 : 2'b01;
        ta  = c.is_read ? 2'b11 : 2'b10;
        dat = c.is_read ? 16'hFFFF : c.wdata;
        return {{PRE_BITS{1'b1}}, 2'b01, op, c.phy, c.regn, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int CLK_DIV = 48
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int HALF = CLK_DIV / 2;
    localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
    localparam logic [CW-1:0] LAST    = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] HALF_V  = CW'(HALF);
    localparam logic [CW-1:0] HALF_M1 = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_n;

    always_comb begin
        cnt_n     = (cnt == LAST) ? '0 : cnt + 1'b1;
        rise_tick = run && (cnt == HALF_M1);
        fall_tick = run && (cnt == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else begin
            cnt <= cnt_n;
            mdc <= (cnt_n >= HALF_V);
        end
    end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        start,
    input  mdio_cmd_t   cmd,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        busy,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic        rd_done,
    output logic [15:0] rd_data
);
    logic [FRAME_BITS-1:0] shreg;
    logic [BIDX_W-1:0]     bidx;
    logic                  is_rd;
    logic [15:0]           cap;
    logic                  last;

    always_comb begin
        last    = (bidx == BIDX_W'(FRAME_BITS - 1));
        rd_done = busy && en && is_rd && fall_tick && last;
        mdio_o  = shreg[FRAME_BITS-1];
        mdio_oe = busy && !(is_rd && (bidx >= BIDX_W'(TA_IDX)));
        rd_data = cap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            bidx  <= '0;
            is_rd <= 1'b0;
            cap   <= '0;
            busy  <= 1'b0;
        end else if (!en) begin
            busy <= 1'b0;
        end else if (start && !busy) begin
            shreg <= build_frame(cmd);
            bidx  <= '0;
            is_rd <= cmd.is_read;
            cap   <= '0;
            busy  <= 1'b1;
        end else if (busy) begin
            if (rise_tick && is_rd && (bidx >= BIDX_W'(DATA_IDX)))
                cap <= {cap[14:0], mdio_i};
            if (fall_tick) begin
                if (last) begin
                    busy <= 1'b0;
                end else begin
                    bidx  <= bidx + 1'b1;
                    shreg <= {shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    input  logic        busy,
    input  logic        rd_done,
    input  logic [15:0] rd_data,
    output logic [31:0] reg_rdata,
    output logic        en,
    output logic        start,
    output mdio_cmd_t   cmd,
    output logic [31:0] maint
);
    reg_sel_e sel;
    logic     word_ok;

    always_comb begin
        sel     = reg_sel_e'(reg_addr);
        word_ok = reg_wdata[MW_MARK_HI] && reg_wdata[MW_MARK_LO]
                  && (reg_wdata[MW_RD] ^ reg_wdata[MW_WR]);
        start   = reg_wr && (sel == SEL_MAINT) && en && !busy && word_ok;
        cmd.is_read = reg_wdata[MW_RD];
        cmd.phy     = reg_wdata[MW_PHY_LSB +: 5];
        cmd.regn    = reg_wdata[MW_REG_LSB +: 5];
        cmd.wdata   = reg_wdata[15:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en    <= 1'b0;
            maint <= '0;
        end else begin
            if (reg_wr && (sel == SEL_CTRL))
                en <= reg_wdata[CTRL_EN_BIT];
            if (start)
                maint <= reg_wdata;
            else if (rd_done)
                maint[15:0] <= rd_data;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CTRL:  reg_rdata[CTRL_EN_BIT]   = en;
            SEL_STAT:  reg_rdata[STAT_IDLE_BIT] = !busy;
            SEL_MAINT: reg_rdata                = maint;
            SEL_NONE:  reg_rdata                = '0;
        endcase
    end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    logic        busy_w;
    logic        en_w;
    logic        start_w;
    logic        rd_done_w;
    logic [15:0] rd_data_w;
    logic [31:0] maint_w;
    logic        rise_w;
    logic        fall_w;
    mdio_cmd_t   cmd_w;

    mdio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .busy      (busy_w),
        .rd_done   (rd_done_w),
        .rd_data   (rd_data_w),
        .reg_rdata (reg_rdata),
        .en        (en_w),
        .start     (start_w),
        .cmd       (cmd_w),
        .maint     (maint_w)
    );

    mdio_mdc_gen #(.CLK_DIV(CLK_DIV)) u_mdc (
        .clk       (clk),
        .rst       (rst),
        .run       (busy_w && en_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (en_w),
        .start     (start_w),
        .cmd       (cmd_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .mdio_i    (mdio_i),
        .busy      (busy_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_done   (rd_done_w),
        .rd_data   (rd_data_w)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [3:0]  marks,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        en,
    input logic        rd_done,
    input logic [31:0] maint
);
    logic word_ok;
    assign word_ok = marks[3] && marks[0] && (marks[2] ^ marks[1]);

    // R9
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe));

    // R10
    pin_stable_high_chk: assert property (@(posedge clk) disable iff (rst)
        (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

    // R5
    idle_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && word_ok && en && !busy) |=> busy);

    // R8
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && busy && !rd_done) |=> $stable(maint));

    // R2
    bad_word_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd2 && !word_ok && !rd_done) |=> $stable(maint));

    // R7
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !busy);

    // R4
    read_released_chk: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> !mdio_oe);
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .marks    ({reg_wdata[30], reg_wdata[29], reg_wdata[28], reg_wdata[17]}),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .en       (en_w),
    .rd_done  (rd_done_w),
    .maint    (maint_w)
);

// File: tb/mdio_mgmt_ctrl_tb_top.sv
module mdio_mgmt_ctrl_tb_top;
    localparam int DIV  = 8;
    localparam int HALF = DIV / 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [1:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl #(.CLK_DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // bench PHY model
    int          rcnt;
    logic [63:0] cap;
    logic [63:0] oe_bits;
    logic        phy_rd;
    logic [15:0] phy_resp;

    always @(posedge mdc) begin
        int nx;
        if (rcnt < 64) begin
            cap[63-rcnt]     = mdio_o;
            oe_bits[63-rcnt] = mdio_oe;
        end
        rcnt = rcnt + 1;
        nx = rcnt;
        if (phy_rd && nx >= 48 && nx <= 63) mdio_i = phy_resp[15-(nx-48)];
        else if (phy_rd && nx == 47)        mdio_i = 1'b0;
        else                                mdio_i = 1'b1;
    end

    // MDC shape and pin stability monitor
    logic prev_mdc = 0, prev_o = 0, prev_oe = 0;
    int   hi_run = 0, lo_run = 0, mdc_bad = 0, r10_bad = 0;
    bit   lo_valid = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
                r10_bad++;
            if (mdc && !prev_mdc) begin
                if (lo_valid && lo_run != HALF) mdc_bad++;
                lo_valid = 0;
                hi_run = 1;
            end else if (mdc) begin
                hi_run++;
            end else if (prev_mdc) begin
                if (hi_run != DIV - HALF) mdc_bad++;
                lo_valid = 1;
                lo_run = 1;
            end else begin
                lo_run++;
            end
        end
        prev_mdc = mdc;
        prev_o   = mdio_o;
        prev_oe  = mdio_oe;
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] mk_word(input bit rd, input bit wr,
        input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] dat);
        return (32'd1 << 30) | (32'(rd) << 29) | (32'(wr) << 28) |
               (32'(phy) << 23) | (32'(rg) << 18) | (32'd1 << 17) | 32'(dat);
    endfunction

    function automatic logic [63:0] exp_frame(input bit rd, input logic [4:0] phy,
        input logic [4:0] rg, input logic [15:0] dat);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
                (rd ? 2'b00 : 2'b10), (rd ? 16'h0000 : dat)};
    endfunction

    logic [31:0] cur_word;
    logic [63:0] cur_frame;
    bit          cur_rd;
    logic [15:0] cur_resp;

    task automatic launch(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                          input logic [15:0] dat, input logic [15:0] resp);
        logic [31:0] s;
        rcnt = 0; lo_valid = 0;
        phy_rd = rd; phy_resp = resp;
        cur_rd = rd; cur_resp = resp;
        cur_word  = mk_word(rd, !rd, phy, rg, dat);
        cur_frame = exp_frame(rd, phy, rg, dat);
        wr_reg(2'd2, cur_word);
        rd_reg(2'd1, s);
        check(s == 32'h0, "R5 busy status", 64'(s), 64'h0);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            rd_reg(2'd1, s);
            if (s[2]) break;
        end
    endtask

    task automatic finish_frame();
        logic [31:0] m;
        wait_idle();
        check(rcnt == 64, "R1 mdc period count", 64'(rcnt), 64'd64);
        rd_reg(2'd2, m);
        if (cur_rd) begin
            check(cap[63:18] == cur_frame[63:18], "R1 R2 read header",
                  64'(cap[63:18]), 64'(cur_frame[63:18]));
            check(oe_bits == {{46{1'b1}}, 18'h0}, "R4 release", oe_bits,
                  {{46{1'b1}}, 18'h0});
            check(m == {cur_word[31:16], cur_resp}, "R4 read result", 64'(m),
                  64'({cur_word[31:16], cur_resp}));
        end else begin
            check(cap == cur_frame, "R1 R3 write frame", cap, cur_frame);
            check(oe_bits == '1, "R3 drive", oe_bits, '1);
            check(m == cur_word, "R3 word kept", 64'(m), 64'(cur_word));
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] saved;
        int          sr;
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; mdio_i = 1;
        rcnt = 0; phy_rd = 0; phy_resp = 0; cap = 0; oe_bits = 0;
        v = $urandom(32'd4242);
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);

        rd_reg(2'd1, v); check(v == 32'h4, "R5 reset status", 64'(v), 64'h4);
        rd_reg(2'd0, v); check(v == 32'h0, "R6 reset ctrl", 64'(v), 64'h0);
        rd_reg(2'd2, v); check(v == 32'h0, "R1 reset word", 64'(v), 64'h0);
        check(!mdc && !mdio_oe, "R9 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);

        // R6 enable
        wr_reg(2'd0, 32'h10);
        rd_reg(2'd0, v); check(v == 32'h10, "R6 ctrl readback", 64'(v), 64'h10);

        mdc_bad = 0; r10_bad = 0;
        launch(0, 5'h01, 5'h02, 16'hA5C3, 16'h0);  finish_frame();
        launch(1, 5'h1F, 5'h00, 16'hBEEF, 16'h1234); finish_frame();
        launch(1, 5'h00, 5'h1F, 16'h0000, 16'hFFFF); finish_frame();
        launch(1, 5'h15, 5'h0A, 16'h5555, 16'h0000); finish_frame();
        launch(0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0);  finish_frame();
        launch(0, 5'h00, 5'h00, 16'h0000, 16'h0);  finish_frame();
        for (int k = 0; k < 10; k++) begin
            launch($urandom % 2, 5'($urandom), 5'($urandom), 16'($urandom),
                   16'($urandom));
            finish_frame();
        end
        check(mdc_bad == 0, "R9 mdc shape", 64'(mdc_bad), 64'h0);
        check(r10_bad == 0, "R10 pin stable while mdc high", 64'(r10_bad), 64'h0);

        // R8: write while busy
        launch(0, 5'h03, 5'h04, 16'h1357, 16'h0);
        repeat (40) @(negedge clk);
        wr_reg(2'd2, mk_word(1, 0, 5'h1E, 5'h1D, 16'h2468));
        finish_frame();
        rd_reg(2'd2, v);
        check(v == cur_word, "R8 busy write ignored", 64'(v), 64'(cur_word));

        // R2: malformed words
        saved = cur_word;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] bad;
            case (k)
                0: bad = mk_word(0, 1, 5'h2, 5'h3, 16'h1) & ~(32'd1 << 30);
                1: bad = mk_word(0, 1, 5'h2, 5'h3, 16'h1) & ~(32'd1 << 17);
                2: bad = mk_word(1, 1, 5'h2, 5'h3, 16'h1);
                default: bad = mk_word(0, 0, 5'h2, 5'h3, 16'h1);
            endcase
            rcnt = 0;
            wr_reg(2'd2, bad);
            repeat (2 * DIV) @(negedge clk);
            rd_reg(2'd1, v);
            check(v == 32'h4 && rcnt == 0, "R2 bad word no frame",
                  64'(rcnt), 64'h0);
            rd_reg(2'd2, v);
            check(v == saved, "R2 bad word not stored", 64'(v), 64'(saved));
        end

        // R6: disabled port ignores commands
        wr_reg(2'd0, 32'h0);
        rcnt = 0;
        wr_reg(2'd2, mk_word(0, 1, 5'h7, 5'h8, 16'h9));
        repeat (2 * DIV) @(negedge clk);
        rd_reg(2'd2, v);
        check(v == saved && rcnt == 0, "R6 disabled ignores", 64'(v), 64'(saved));

        // R7: abort mid-frame
        wr_reg(2'd0, 32'h10);
        launch(1, 5'h09, 5'h0B, 16'h0, 16'hC0DE);
        repeat (100) @(negedge clk);
        wr_reg(2'd0, 32'h0);
        repeat (2) @(negedge clk);
        rd_reg(2'd1, v);
        check(v == 32'h4, "R7 idle after abort", 64'(v), 64'h4);
        check(!mdc && !mdio_oe, "R7 pins low after abort",
              {62'h0, mdc, mdio_oe}, 64'h0);
        sr = rcnt;
        repeat (4 * DIV) @(negedge clk);
        check(rcnt == sr && sr < 64, "R7 no more mdc", 64'(rcnt), 64'(sr));

        // R1: port works again after re-enable
        wr_reg(2'd0, 32'h10);
        launch(0, 5'h11, 5'h12, 16'h8001, 16'h0); finish_frame();

        finished = 1;
        summary();
        $finish;
    end
endmodule